// File: doc/BRIEF.md
# AUX Reply Timeout Timer

This block watches for a reply on an auxiliary channel receiver and raises a flag when none arrives in time. Firmware asks for a timeout in microseconds through a one-cycle configuration write. The block turns that request into a compact setting: a 7-bit length and a 2-bit unit selector. The selector picks a unit of 8, 16, 32 or 64 microseconds. The length is the request divided by the unit, rounded up and capped at 127. A request of zero selects a default setting.

Each configuration write also reports what was programmed before it. That earlier setting is given as its length times its unit, in microseconds, so a caller can put it back later. A separate timer counts microsecond ticks after an arm pulse. It stops when a reply is seen or when it is cleared. It sets `timeout` once the tick count reaches the length times the unit that was active at the moment of arming.

Top module: `aux_reply_timer`

## Requirements
- R1: A request of 0 µs selects unit selector 0 (8 µs) with length 69, which is a limit of 552 µs. The same default setting is in force after reset.
- R2: Any nonzero request selects a unit from its size. Up to 1016 µs gives selector 0 (8 µs). 1017–2032 µs gives selector 1 (16 µs). 2033–4064 µs gives selector 2 (32 µs). Above 4064 µs gives selector 3 (64 µs).
- R3: The length is the request divided by the selected unit, rounded up whenever there is a remainder.
- R4: The length never exceeds 127. For example, a 60000 µs request gives selector 3 with length 127, a limit of 8128 µs.
- R5: On the clock edge that takes a configuration write, `prev_us` loads the setting in force before that write, as length × unit. With no write it holds its value. After reset it reads 0.
- R6: An `arm` pulse restarts the count from zero and clears `timeout`. While armed, each edge with `us_tick` high adds one. On the edge where the count reaches the limit, `timeout` goes high and counting stops. `timeout` then stays high until `clear` or `arm`.
- R7: `reply_seen` while armed stops the count, so no timeout follows.
- R8: `clear` stops the count and drops `timeout`. When inputs arrive together, `clear` wins over `arm`, and `arm` wins over `reply_seen`.
- R9: The limit is captured at arming. A configuration write during a run, or in the same cycle as `arm`, takes effect only at the next arm.
- R10: Ticks while the timer is not armed have no effect, and `timeout` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | One-cycle configuration write strobe |
| cfg_us | input | CFG_W | Requested timeout in microseconds |
| prev_us | output | 13 | Earlier setting in µs, captured at the last write |
| arm | input | 1 | Start a new timing window |
| clear | input | 1 | Stop the timer and drop the timeout flag |
| reply_seen | input | 1 | A reply has arrived; stop counting |
| us_tick | input | 1 | One-cycle microsecond tick |
| timeout | output | 1 | Limit reached without a reply |

## Verification
The bench builds the block with CFG_W = 16. This lets requests go far past the 127 × 64 clamp point, so every unit band and the cap are reached. Requests are placed exactly on and just past each band edge (1016/1017, 2032/2033, 4064/4065). The timer runs to the 24, 8 and 552 µs limits with ticks on every cycle, which keeps the full default window within a short run. A behavioural model is checked against the design on every cycle.

// File: rtl/aux_tmr_pkg.sv
package aux_tmr_pkg;
  localparam int LEN_W      = 7;
  localparam int MUL_W      = 2;
  localparam int BASE_SHIFT = 3;
  localparam int STEP_US    = 1016;
  localparam int DEF_LEN    = 69;
  localparam int LIM_W      = LEN_W + BASE_SHIFT + (1 << MUL_W) - 1;

  typedef struct packed {
    logic [MUL_W-1:0] mul;
    logic [LEN_W-1:0] len;
  } tmo_set_t;

  function automatic logic [LIM_W-1:0] set_to_us(input tmo_set_t s);
    logic [LIM_W-1:0] l;
    l = LIM_W'(s.len);
    case (s.mul)
      2'd0:    return l << BASE_SHIFT;
      2'd1:    return l << (BASE_SHIFT + 1);
      2'd2:    return l << (BASE_SHIFT + 2);
      2'd3:    return l << (BASE_SHIFT + 3);
      default: return LIM_W'(DEF_LEN) << BASE_SHIFT;
    endcase
  endfunction
endpackage

// File: rtl/aux_tmr_conv.sv
module aux_tmr_conv
  import aux_tmr_pkg::*;
#(
  parameter int CFG_W = 16
) (
  input  logic [CFG_W-1:0] req_us,
  output tmo_set_t         set_o
);
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  logic [31:0]      req_ext;
  logic [MUL_W-1:0] mul;
  logic [2:0]       sh;
  logic [31:0]      rnd;

  always_comb begin
    req_ext = 32'(req_us);
    if (req_ext <= 32'(STEP_US))          mul = 2'd0;
    else if (req_ext <= 32'(2 * STEP_US)) mul = 2'd1;
    else if (req_ext <= 32'(4 * STEP_US)) mul = 2'd2;
    else                                  mul = 2'd3;
    sh  = 3'(BASE_SHIFT) + 3'(mul);
    rnd = (req_ext + (32'd1 << sh) - 32'd1) >> sh;
    if (req_ext == 32'd0) begin
      set_o.mul = '0;
      set_o.len = LEN_W'(DEF_LEN);
    end else begin
      set_o.mul = mul;
      set_o.len = (rnd > 32'(LEN_MAX)) ? LEN_MAX : rnd[LEN_W-1:0];
    end
  end
endmodule

// File: rtl/aux_tmr_setting.sv
module aux_tmr_setting
  import aux_tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  tmo_set_t         new_set,
  output tmo_set_t         cur_set,
  output logic [LIM_W-1:0] prev_us
);
  tmo_set_t         set_q, set_d;
  logic [LIM_W-1:0] prev_q, prev_d;

  always_comb begin
    set_d  = set_q;
    prev_d = prev_q;
    if (wr_en) begin
      set_d  = new_set;
      prev_d = set_to_us(set_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q.mul <= '0;
      set_q.len <= LEN_W'(DEF_LEN);
      prev_q    <= '0;
    end else if (wr_en) begin
      set_q  <= set_d;
      prev_q <= prev_d;
    end
  end

  assign cur_set = set_q;
  assign prev_us = prev_q;
endmodule

// File: rtl/aux_tmr_counter.sv
module aux_tmr_counter
  import aux_tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             clear,
  input  logic             reply,
  input  logic             tick,
  input  logic [LIM_W-1:0] limit_in,
  output logic             running,
  output logic             timeout
);
  logic             run_q, run_d;
  logic             to_q, to_d;
  logic [LIM_W-1:0] cnt_q, cnt_d, lim_q, lim_d, cnt_inc;

  always_comb begin
    run_d   = run_q;
    to_d    = to_q;
    cnt_d   = cnt_q;
    lim_d   = lim_q;
    cnt_inc = cnt_q + LIM_W'(1);
    if (clear) begin
      run_d = 1'b0;
      to_d  = 1'b0;
      cnt_d = '0;
    end else if (arm) begin
      run_d = 1'b1;
      to_d  = 1'b0;
      cnt_d = '0;
      lim_d = limit_in;
    end else if (run_q && reply) begin
      run_d = 1'b0;
    end else if (run_q && tick) begin
      cnt_d = cnt_inc;
      if (cnt_inc == lim_q) begin
        to_d  = 1'b1;
        run_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      to_q  <= 1'b0;
      cnt_q <= '0;
      lim_q <= '0;
    end else begin
      run_q <= run_d;
      to_q  <= to_d;
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end

  assign running = run_q;
  assign timeout = to_q;
endmodule

// File: rtl/aux_reply_timer.sv
module aux_reply_timer
  import aux_tmr_pkg::*;
#(
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_us,
  output logic [LIM_W-1:0] prev_us,
  input  logic             arm,
  input  logic             clear,
  input  logic             reply_seen,
  input  logic             us_tick,
  output logic             timeout
);
  tmo_set_t         req_set, cur_set;
  logic [LIM_W-1:0] cur_limit;
  logic             running;

  aux_tmr_conv #(.CFG_W(CFG_W)) u_conv (
    .req_us (cfg_us),
    .set_o  (req_set)
  );

  aux_tmr_setting u_setting (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr),
    .new_set (req_set),
    .cur_set (cur_set),
    .prev_us (prev_us)
  );

  assign cur_limit = set_to_us(cur_set);

  aux_tmr_counter u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (arm),
    .clear    (clear),
    .reply    (reply_seen),
    .tick     (us_tick),
    .limit_in (cur_limit),
    .running  (running),
    .timeout  (timeout)
  );
endmodule

// File: rtl/aux_reply_timer_chk.sv
module aux_reply_timer_chk
  import aux_tmr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic             arm,
  input logic             clear,
  input logic             reply_seen,
  input logic             us_tick,
  input logic [LIM_W-1:0] prev_us,
  input logic             timeout,
  input logic             running
);
  a_r4_prev_capped: assert property (@(posedge clk) disable iff (!rst_n)
    prev_us <= LIM_W'(127 * 64));

  a_r5_prev_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(prev_us));

  a_r6_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> $past(us_tick) && $past(running));

  a_r6_stopped_after: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> !running);

  a_r7_reply_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    reply_seen && !arm && !clear && !timeout |=> !timeout);

  a_r8_clear_low: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !timeout && !running);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !arm && !timeout |=> !timeout);
endmodule

bind aux_reply_timer aux_reply_timer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wr     (cfg_wr),
  .arm        (arm),
  .clear      (clear),
  .reply_seen (reply_seen),
  .us_tick    (us_tick),
  .prev_us    (prev_us),
  .timeout    (timeout),
  .running    (running)
);

// File: tb/aux_reply_timer_bench.sv
module aux_reply_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CFG_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_wr = 1'b0;
  logic [CFG_W-1:0] cfg_us = '0;
  logic [12:0]      prev_us;
  logic             arm = 1'b0, clear = 1'b0, reply_seen = 1'b0, us_tick = 1'b0;
  logic             timeout;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  string cur_req = "R5";

  // reference model state
  int m_mul = 0, m_len = 69, m_prev = 0;
  int m_cnt = 0, m_lim = 0;
  bit m_run = 0, m_to = 0;

  aux_reply_timer #(.CFG_W(CFG_W)) u_aux_reply_timer (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_us(cfg_us),
    .prev_us(prev_us), .arm(arm), .clear(clear),
    .reply_seen(reply_seen), .us_tick(us_tick), .timeout(timeout)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int unit_of(int mul);
    return 8 * (2 ** mul);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mul = 0; m_len = 69; m_prev = 0;
      m_cnt = 0; m_lim = 0; m_run = 0; m_to = 0;
    end else begin
      if (clear) begin
        m_run = 0; m_to = 0; m_cnt = 0;
      end else if (arm) begin
        m_run = 1; m_to = 0; m_cnt = 0;
        m_lim = m_len * unit_of(m_mul);
      end else if (m_run && reply_seen) begin
        m_run = 0;
      end else if (m_run && us_tick) begin
        m_cnt++;
        if (m_cnt == m_lim) begin m_to = 1; m_run = 0; end
      end
      if (cfg_wr) begin
        int u;
        int x;
        x = int'(cfg_us);
        m_prev = m_len * unit_of(m_mul);
        if (x == 0) begin
          m_mul = 0; m_len = 69;
        end else begin
          if (x <= 1016) m_mul = 0;
          else if (x <= 2032) m_mul = 1;
          else if (x <= 4064) m_mul = 2;
          else m_mul = 3;
          u = unit_of(m_mul);
          m_len = (x + u - 1) / u;
          if (m_len > 127) m_len = 127;
        end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({cur_req, " model timeout"}, int'(timeout), int'(m_to));
      chk({cur_req, " model prev_us"}, int'(prev_us), m_prev);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int us);
    cfg_us = CFG_W'(us); cfg_wr = 1'b1; cyc(1); cfg_wr = 1'b0;
  endtask

  task automatic do_arm();
    arm = 1'b1; cyc(1); arm = 1'b0;
  endtask

  task automatic do_clear();
    clear = 1'b1; cyc(1); clear = 1'b0;
  endtask

  task automatic ticks(int n);
    us_tick = 1'b1; cyc(n); us_tick = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    cyc(2);
    // R5 / R1: reset state
    chk("R5 reset prev_us", int'(prev_us), 0);
    chk("R6 reset timeout", int'(timeout), 0);
    rst_n = 1'b1;
    cyc(1);

    // R1: default after reset is 69 x 8
    cur_req = "R1";
    wr(100);  chk("R1 reset default reported", int'(prev_us), 552);
    cur_req = "R3";
    wr(1016); chk("R3 100us -> 13 x 8", int'(prev_us), 104);
    cur_req = "R2";
    wr(1017); chk("R2 1016 stays unit 8", int'(prev_us), 1016);
    wr(2032); chk("R2 1017 -> 64 x 16", int'(prev_us), 1024);
    wr(2033); chk("R2 2032 -> 127 x 16", int'(prev_us), 2032);
    wr(4064); chk("R2 2033 -> 64 x 32", int'(prev_us), 2048);
    wr(4065); chk("R2 4064 -> 127 x 32", int'(prev_us), 4064);
    cur_req = "R4";
    wr(60000); chk("R4 4065 -> 64 x 64", int'(prev_us), 4096);
    wr(8);    chk("R4 60000 clamps to 127 x 64", int'(prev_us), 8128);
    cur_req = "R1";
    wr(0);    chk("R1 8us -> 1 x 8", int'(prev_us), 8);
    wr(20);   chk("R1 zero request -> default", int'(prev_us), 552);
    cur_req = "R5";
    cyc(3);   chk("R5 prev held without write", int'(prev_us), 552);

    // R6: limit 24
    cur_req = "R6";
    do_arm();
    ticks(23); chk("R6 no timeout before limit", int'(timeout), 0);
    ticks(1);  chk("R6 timeout at limit", int'(timeout), 1);
    ticks(5);  chk("R6 timeout sticky", int'(timeout), 1);
    cur_req = "R8";
    do_clear(); chk("R8 clear drops timeout", int'(timeout), 0);

    // R7: reply stops the count
    cur_req = "R7";
    do_arm(); ticks(10);
    reply_seen = 1'b1; cyc(1); reply_seen = 1'b0;
    ticks(40); chk("R7 no timeout after reply", int'(timeout), 0);

    // R9: write during run applies at next arm
    cur_req = "R9";
    do_arm(); ticks(5);
    wr(8);
    ticks(18); chk("R9 old limit still in force", int'(timeout), 0);
    ticks(1);  chk("R9 timeout at old limit 24", int'(timeout), 1);
    do_clear();
    do_arm(); ticks(7); chk("R9 new limit not yet", int'(timeout), 0);
    ticks(1);  chk("R9 timeout at new limit 8", int'(timeout), 1);

    // R10: idle ticks do nothing
    cur_req = "R10";
    do_clear(); ticks(100); chk("R10 idle ticks ignored", int'(timeout), 0);

    // R8: clear beats arm
    cur_req = "R8";
    arm = 1'b1; clear = 1'b1; cyc(1); arm = 1'b0; clear = 1'b0;
    ticks(30); chk("R8 clear wins over arm", int'(timeout), 0);

    // R8: arm beats reply
    arm = 1'b1; reply_seen = 1'b1; cyc(1); arm = 1'b0; reply_seen = 1'b0;
    ticks(8); chk("R8 arm wins over reply", int'(timeout), 1);

    // R9: arm with write in same cycle uses old setting (8)
    cur_req = "R9";
    cfg_us = CFG_W'(40); cfg_wr = 1'b1; arm = 1'b1; cyc(1);
    cfg_wr = 1'b0; arm = 1'b0;
    ticks(8); chk("R9 same-cycle arm keeps old limit", int'(timeout), 1);

    // R1: default window end to end
    cur_req = "R1";
    wr(0); do_arm();
    ticks(551); chk("R1 default not reached", int'(timeout), 0);
    ticks(1);   chk("R1 default limit 552", int'(timeout), 1);

    cyc(2);
    finish_run();
  end
endmodule